// File: doc/BRIEF.md
# Four-Operation Registered Arithmetic Unit

This block is a small unsigned arithmetic unit. It takes two 4-bit operands and a 2-bit operation code. On every rising clock edge it captures one 4-bit result: the sum, the difference, the product or the quotient. Addition and subtraction share one carry look-ahead adder. Every carry of that adder is expanded in parallel from the carry-in, using the per-bit generate term (AND of the operand bits) and propagate term (XOR of the operand bits). Subtraction adds the inverted second operand with a carry-in of one.

Multiplication is a shift-and-add array. Division is a restoring long divider. Both are combinational and keep only the low 4 bits. The registered adder carry-out doubles as a no-borrow flag during subtraction. A separate registered flag marks a divide by zero. The unit has no state machine: a single output register holds the result, and the operation code picks what it loads.

Top module: `arith4_unit`

## Requirements
- R1: An active-high synchronous reset sets result, carry_out and div_zero to 0 at the next rising edge.
- R2: With op_sel = 2'b00, the result after the next rising edge is (A + B) mod 16.
- R3: With op_sel = 2'b00, carry_out after the edge is 1 exactly when A + B > 15.
- R4: With op_sel = 2'b01, the result after the edge is (A − B) mod 16, formed as A + ~B + 1.
- R5: With op_sel = 2'b01, carry_out after the edge is 1 exactly when A ≥ B (no borrow).
- R6: With op_sel = 2'b10, the result after the edge is the low 4 bits of A × B.
- R7: With op_sel = 2'b11 and B ≠ 0, the result after the edge is floor(A / B).
- R8: With op_sel = 2'b11 and B = 0, the result after the edge is 4'b1111 and div_zero is 1 for that cycle.
- R9: div_zero is 0 after any edge that did not capture a divide by zero, and carry_out is 0 after any edge that captured a multiply or a divide.
- R10: Outputs change only at a rising clock edge; an input change between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| opnd_a | input | 4 | First operand, unsigned |
| opnd_b | input | 4 | Second operand, unsigned |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 divide |
| result | output | 4 | Registered result |
| carry_out | output | 1 | Registered carry (add) or no-borrow (subtract), else 0 |
| div_zero | output | 1 | Registered divide-by-zero flag |

## Verification
Every operand pair is applied under every operation code. This catches a look-ahead term that drops one generate or propagate product: such a design gives wrong sums only for the pairs whose carry chains run through that term. On subtraction the bench checks the A = B and A < B boundaries. An inverted or missing carry-in would give results off by one there, and the no-borrow flag would be wrong. The divide-by-zero cases confirm the all-ones result, and they confirm that the flag clears on the very next non-zero divide. A flag that sticks, or a divider that leaks its raw quotient, would show up there. A hold test changes the inputs between edges. A design that drives its outputs combinationally would fail it.

// File: rtl/arith4_pkg.sv
package arith4_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } op_e;
endpackage

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W:0]   cy;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i] = a[i] & b[i];
        assign prp[i] = a[i] ^ b[i];
        assign sum[i] = prp[i] ^ cy[i];
    end

    // Each carry is a flat sum of products from cin, not a ripple.
    always_comb begin
        cy[0] = cin;
        for (int i = 0; i < W; i++) begin
            logic acc;
            logic term;
            term = cin;
            for (int k = 0; k <= i; k++) term = term & prp[k];
            acc = term;
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prp[k];
                acc = acc | term;
            end
            cy[i+1] = acc;
        end
    end

    assign cout = cy[W];

    // R2 R4: look-ahead sum agrees with plain addition
    always_comb begin
        if (!$isunknown({a, b, cin}))
            a_r2_cla_sum: assert ({cout, sum} ==
                ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
    end
endmodule

// File: rtl/mul_trunc.sv
module mul_trunc #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod
);
    localparam int PW = 2 * W;
    logic [PW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) acc = acc + ({{W{1'b0}}, a} << i);
        end
    end

    assign prod = acc[W-1:0];
endmodule

// File: rtl/div_restore.sv
module div_restore #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo
);
    logic [W:0] rem;

    always_comb begin
        rem = '0;
        quo = '0;
        for (int i = W - 1; i >= 0; i--) begin
            rem = {rem[W-1:0], a[i]};
            if (rem >= {1'b0, b}) begin
                rem    = rem - {1'b0, b};
                quo[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arith4_unit.sv
module arith4_unit
    import arith4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         div_zero
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    op_e          op;
    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] mul_res;
    logic [W-1:0] div_res;
    logic [W-1:0] res_nx;
    logic         cy_nx;
    logic         dz_nx;

    assign op      = op_e'(op_sel);
    assign add_b   = (op == OP_SUB) ? ~opnd_b : opnd_b;
    assign add_cin = (op == OP_SUB);

    cla_adder   #(.W(W)) u_cla (.a(opnd_a), .b(add_b), .cin(add_cin),
                                .sum(add_sum), .cout(add_cout));
    mul_trunc   #(.W(W)) u_mul (.a(opnd_a), .b(opnd_b), .prod(mul_res));
    div_restore #(.W(W)) u_div (.a(opnd_a), .b(opnd_b), .quo(div_res));

    always_comb begin
        res_nx = '0;
        cy_nx  = 1'b0;
        dz_nx  = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res_nx = add_sum;
                cy_nx  = add_cout;
            end
            OP_MUL: res_nx = mul_res;
            OP_DIV: begin
                if (opnd_b == '0) begin
                    res_nx = ALL_ONES;
                    dz_nx  = 1'b1;
                end else begin
                    res_nx = div_res;
                end
            end
            default: res_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            carry_out <= 1'b0;
            div_zero  <= 1'b0;
        end else begin
            result    <= res_nx;
            carry_out <= cy_nx;
            div_zero  <= dz_nx;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry_out && !div_zero));

    a_r2_add_value: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b00) |=>
            result == W'($past(opnd_a) + $past(opnd_b)));

    a_r5_no_borrow: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b01) |=> (carry_out == ($past(opnd_a) >= $past(opnd_b))));

    a_r8_div_zero: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11 && opnd_b == '0) |=> (div_zero && result == ALL_ONES));

    a_r9_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        !(op_sel == 2'b11 && opnd_b == '0) |=> !div_zero);

    a_r9_no_carry: assert property (@(posedge clk) disable iff (rst)
        op_sel[1] |=> !carry_out);
endmodule

// File: tb/tb_arith4_unit.sv
module tb_arith4_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [1:0] op_sel = '0;
    logic [3:0] result;
    logic       carry_out;
    logic       div_zero;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    arith4_unit dut (.clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
                     .op_sel(op_sel), .result(result), .carry_out(carry_out),
                     .div_zero(div_zero));

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s a=%0d b=%0d op=%0d actual=%0d expected=%0d",
                     req, opnd_a, opnd_b, op_sel, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int op);
        @(negedge clk);
        opnd_a = 4'(a);
        opnd_b = 4'(b);
        op_sel = 2'(op);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        apply(9, 9, 0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 result", result, 0);
        chk("R1 carry", carry_out, 0);
        chk("R1 dz", div_zero, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_add();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                apply(a, b, 0);
                chk("R2", result, (a + b) % 16);
                chk("R3", carry_out, (a + b > 15) ? 1 : 0);
                chk("R9 add dz", div_zero, 0);
            end
    endtask

    task automatic t_sub();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                apply(a, b, 1);
                chk("R4", result, (a - b + 16) % 16);
                chk("R5", carry_out, (a >= b) ? 1 : 0);
            end
    endtask

    task automatic t_mul();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                apply(a, b, 2);
                chk("R6", result, (a * b) % 16);
                chk("R9 mul carry", carry_out, 0);
                chk("R9 mul dz", div_zero, 0);
            end
    endtask

    task automatic t_div();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                apply(a, b, 3);
                chk("R9 div carry", carry_out, 0);
                if (b == 0) begin
                    chk("R8 result", result, 15);
                    chk("R8 flag", div_zero, 1);
                end else begin
                    chk("R7", result, a / b);
                    chk("R9 div dz", div_zero, 0);
                end
            end
    endtask

    task automatic t_divzero_then_clear();
        apply(15, 15, 0);
        apply(7, 0, 3);
        chk("R8 flag", div_zero, 1);
        chk("R8 result", result, 15);
        apply(7, 2, 3);
        chk("R9 flag clears", div_zero, 0);
        chk("R7", result, 3);
    endtask

    task automatic t_hold();
        int held;
        apply(5, 3, 2);
        held = int'(result);
        @(negedge clk);
        opnd_a = 4'd12; opnd_b = 4'd1; op_sel = 2'b00;
        #1;
        chk("R10 hold result", result, held);
        chk("R10 hold carry", carry_out, 0);
        @(posedge clk); #1;
        chk("R10 update", result, 13);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 result", result, 0);
        chk("R1 carry", carry_out, 0);
        chk("R1 dz", div_zero, 0);
        @(negedge clk); rst = 1'b0;
        t_add();
        t_sub();
        t_mul();
        t_div();
        t_divzero_then_clear();
        t_hold();
        t_reset();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule